// File: doc/BRIEF.md
# Three-Rail Soft-Start Power-Up Sequencer

This block is the digital power-up controller for a supply with three rails: a main boost rail, a positive gate rail and a negative gate rail. It watches three synchronous flags. The first says the input supply has cleared its lockout check. The second says the reference is valid. The third is a latched fault indication. When the supply and reference flags are both high, it enables all three rails together. It then drives each rail's 7-bit soft-start DAC code through its ramp, and each ramp has its own step period.

The main and positive gate rails count their codes upward from zero to full scale. The negative gate rail counts down from full scale to a floor code of about one fifth of full scale. When every ramp has finished, the supply is still good and no fault is present, a post-ramp delay counter runs. When the counter reaches its terminal count, the switch-control stage is enabled.

A drop of the supply flag removes every enable in the same cycle and returns the sequence to its start. A fault removes every enable in the same cycle and freezes the codes until the supply flag cycles low and high again.

Top module: `softstart_seq`

## Requirements
- R1: After reset the main and positive gate codes are 0, the negative gate code is 127, and every bit of `rail_en_o` and `rail_done_o` is 0, as is `sw_en_o`.
- R2: The rails start only once `supply_ok_i` and `ref_ok_i` are both high. All three bits of `rail_en_o` (bit 0 main, bit 1 positive gate, bit 2 negative gate) rise together at the clock edge that samples both flags high.
- R3: While enabled, the main and positive gate codes rise by exactly one per step, from 0 to 127, and then hold.
- R4: While enabled, the negative gate code falls by exactly one per step, from 127 to `NGATE_FLOOR` (default 25), and then holds.
- R5: Each rail has its own step period in clock cycles (`MAIN_STEP_CYC`, `PGATE_STEP_CYC`, `NGATE_STEP_CYC`). The rail's code after k enabled cycles is its start value moved by floor(k / period) steps, limited at its end code. Its `rail_done_o` bit (same bit order as R2) is 1 exactly while the code equals its end code.
- R6: `sw_en_o` rises `SW_DELAY_CYC` cycles after the cycle in which all three done bits are first high, provided the supply stays good and no fault is present. It is never high unless all done bits are high.
- R7: When `supply_ok_i` is low, `rail_en_o` and `sw_en_o` are 0 in that same cycle. At the next edge every code returns to its start value, the done bits and the delay count clear, and the next power-up repeats the full sequence.
- R8: While `fault_lat_i` is high, `rail_en_o` and `sw_en_o` are 0 in that same cycle. The codes stop moving, and they stay stopped with the enables low even after `fault_lat_i` clears, until `supply_ok_i` goes low and returns.
- R9: Once the rails have started, a later drop of `ref_ok_i` has no effect on the enables or the ramps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply has passed its lockout check |
| ref_ok_i | input | 1 | Reference is valid |
| fault_lat_i | input | 1 | Latched fault indication |
| main_code_o | output | 7 | Main boost rail soft-start DAC code |
| pgate_code_o | output | 7 | Positive gate rail soft-start DAC code |
| ngate_code_o | output | 7 | Negative gate rail soft-start DAC code |
| rail_en_o | output | 3 | Rail enables: bit 0 main, bit 1 positive gate, bit 2 negative gate |
| rail_done_o | output | 3 | Ramp complete per rail, same bit order |
| sw_en_o | output | 1 | Switch-control stage enable |

## Verification
The assertions assume that the three flags are already synchronous to `clk` and change only between edges. They also assume that the fault flag comes from an external latch, so it may rise at any point in the ramp. Under those assumptions, the unit-step, range and freeze properties describe every reachable code sequence. The stimulus changes the flags only at the falling clock edge. It then samples the same-cycle enable gating a moment later, and it samples registered results at later falling edges, so no check races a rising edge.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
    localparam int CODE_W = 7;
    localparam int RAILS  = 3;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_TOP = code_t'((1 << CODE_W) - 1);
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp
    import ss_seq_pkg::*;
#(
    parameter int    STEP_CYC = 4,
    parameter code_t START    = code_t'(0),
    parameter code_t STOP     = CODE_TOP
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  run_i,
    output code_t code_o,
    output logic  done_o
);
    localparam int PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [PW-1:0] PC_LAST = PW'(STEP_CYC - 1);
    localparam bit RISING = (STOP > START);
    localparam code_t LO = RISING ? START : STOP;
    localparam code_t HI = RISING ? STOP : START;

    typedef struct packed {
        logic [PW-1:0] pc;
        code_t         code;
    } st_t;

    st_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.code == STOP);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pc   = '0;
            st_d.code = START;
        end else if (run_i && !at_end) begin
            if (st_q.pc == PC_LAST) begin
                st_d.pc   = '0;
                st_d.code = RISING ? st_q.code + 1'b1 : st_q.code - 1'b1;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= '0;
            st_q.code <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign done_o = at_end;

    // R3 / R4: any code movement outside a clear is a single step toward the end code
    p_unit_step_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_i) && (st_q.code != $past(st_q.code))) |->
        (st_q.code == (RISING ? code_t'($past(st_q.code) + 7'd1)
                              : code_t'($past(st_q.code) - 7'd1))));

    // R4: code never leaves the span between start and end
    p_in_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code >= LO) && (st_q.code <= HI));

    // R7: a clear always lands the code on its start value
    p_clear_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (st_q.code == START));
endmodule

// File: rtl/ss_delay.sv
module ss_delay #(
    parameter int DLY_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic go_i,
    output logic term_o
);
    localparam int CW = $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (go_i && (st_q.cnt != LAST)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o = (st_q.cnt == LAST);

    // R7: the count is zero after any cycle with the clear high
    p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (st_q.cnt == '0));

    // R6: without a clear the count never moves backwards
    p_no_retreat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_i) |-> (st_q.cnt >= $past(st_q.cnt)));

    // R6: terminal count is held until cleared
    p_term_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && !clr_i) |=> term_o);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_seq_pkg::*;
#(
    parameter int    MAIN_STEP_CYC  = 79,
    parameter int    PGATE_STEP_CYC = 24,
    parameter int    NGATE_STEP_CYC = 30,
    parameter code_t NGATE_FLOOR    = code_t'(25),
    parameter int    SW_DELAY_CYC   = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        supply_ok_i,
    input  logic        ref_ok_i,
    input  logic        fault_lat_i,
    output logic [6:0]  main_code_o,
    output logic [6:0]  pgate_code_o,
    output logic [6:0]  ngate_code_o,
    output logic [2:0]  rail_en_o,
    output logic [2:0]  rail_done_o,
    output logic        sw_en_o
);
    localparam int    STEP_TAB [RAILS] = '{MAIN_STEP_CYC, PGATE_STEP_CYC, NGATE_STEP_CYC};
    localparam code_t BEG_TAB  [RAILS] = '{code_t'(0), code_t'(0), CODE_TOP};
    localparam code_t END_TAB  [RAILS] = '{CODE_TOP, CODE_TOP, NGATE_FLOOR};

    typedef struct packed {
        logic run;
        logic fhold;
    } st_t;

    st_t st_d, st_q;

    logic             fault_any;
    logic             live;
    logic             ramp_run;
    logic             ramp_clr;
    logic             dly_go;
    logic             dly_term;
    logic [RAILS-1:0] done_w;
    code_t            code_w [RAILS];

    assign fault_any = fault_lat_i | st_q.fhold;
    assign live      = supply_ok_i & ~fault_any;
    assign ramp_run  = st_q.run & live;
    assign ramp_clr  = ~supply_ok_i;
    assign dly_go    = ramp_run & (&done_w);

    always_comb begin
        st_d       = st_q;
        st_d.run   = supply_ok_i & (st_q.run | (ref_ok_i & ~fault_any));
        st_d.fhold = supply_ok_i & (st_q.fhold | fault_lat_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run   <= 1'b0;
            st_q.fhold <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        ss_ramp #(
            .STEP_CYC (STEP_TAB[g]),
            .START    (BEG_TAB[g]),
            .STOP     (END_TAB[g])
        ) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (ramp_clr),
            .run_i  (ramp_run),
            .code_o (code_w[g]),
            .done_o (done_w[g])
        );
    end

    ss_delay #(
        .DLY_CYC (SW_DELAY_CYC)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ramp_clr),
        .go_i   (dly_go),
        .term_o (dly_term)
    );

    assign main_code_o  = code_w[0];
    assign pgate_code_o = code_w[1];
    assign ngate_code_o = code_w[2];
    assign rail_en_o    = {RAILS{ramp_run}};
    assign rail_done_o  = done_w;
    assign sw_en_o      = dly_term & live;

    // R2: the run state only begins from a cycle that saw both flags high
    p_start_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> ($past(supply_ok_i) && $past(ref_ok_i)));

    // R7: a low supply flag leaves no enable standing
    p_off_no_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |-> ((rail_en_o == 3'b000) && !sw_en_o));

    // R6: switch control only with every ramp finished
    p_sw_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_o |-> (rail_done_o == 3'b111));

    // R8: an active fault leaves no enable standing
    p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_lat_i |-> ((rail_en_o == 3'b000) && !sw_en_o));

    // R8: codes stay frozen while a held fault persists with the supply good
    p_fault_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fhold && $past(st_q.fhold) && supply_ok_i && $past(supply_ok_i)) |->
        ($stable(main_code_o) && $stable(pgate_code_o) && $stable(ngate_code_o)));
endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
    typedef struct packed {
        int         k;
        logic [6:0] m;
        logic [6:0] p;
        logic [6:0] n;
        logic [2:0] dn;
    } vec_t;

    // Ramp progress after k enabled cycles: main step 4, pgate step 2, ngate step 3, floor 25
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{0,   7'd0,   7'd0,   7'd127, 3'b000},
        '{3,   7'd0,   7'd1,   7'd126, 3'b000},
        '{9,   7'd2,   7'd4,   7'd124, 3'b000},
        '{100, 7'd25,  7'd50,  7'd94,  3'b000},
        '{253, 7'd63,  7'd126, 7'd43,  3'b000},
        '{254, 7'd63,  7'd127, 7'd43,  3'b010},
        '{305, 7'd76,  7'd127, 7'd26,  3'b010},
        '{306, 7'd76,  7'd127, 7'd25,  3'b110},
        '{507, 7'd126, 7'd127, 7'd25,  3'b110},
        '{508, 7'd127, 7'd127, 7'd25,  3'b111}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       ref_ok = 1'b0;
    logic       fault_lat = 1'b0;
    logic [6:0] main_code, pgate_code, ngate_code;
    logic [2:0] rail_en, rail_done;
    logic       sw_en;

    int checks = 0;
    int errors = 0;
    int k = 0;
    logic [6:0] fm, fp, fn;

    always #5 clk = ~clk;

    softstart_seq #(
        .MAIN_STEP_CYC  (4),
        .PGATE_STEP_CYC (2),
        .NGATE_STEP_CYC (3),
        .NGATE_FLOOR    (7'd25),
        .SW_DELAY_CYC   (10)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok),
        .ref_ok_i     (ref_ok),
        .fault_lat_i  (fault_lat),
        .main_code_o  (main_code),
        .pgate_code_o (pgate_code),
        .ngate_code_o (ngate_code),
        .rail_en_o    (rail_en),
        .rail_done_o  (rail_done),
        .sw_en_o      (sw_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        k++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 main code", main_code, 0);
        chk("R1 pgate code", pgate_code, 0);
        chk("R1 ngate code", ngate_code, 127);
        chk("R1 enables", rail_en, 0);
        chk("R1 done", rail_done, 0);
        chk("R1 sw_en", sw_en, 0);
        rst_n = 1'b1;

        // R2: reference good but supply low: no start
        ref_ok = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 no start without supply", rail_en, 0);
        // R2: supply good but reference low: no start
        ref_ok = 1'b0;
        supply_ok = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 no start without ref", rail_en, 0);
        chk("R2 code held before start", main_code, 0);

        // R2: both high -> all enables together at the next edge
        ref_ok = 1'b1;
        #1;
        chk("R2 enables before edge", rail_en, 0);
        @(negedge clk);
        k = 0;
        chk("R2 all enables together", rail_en, 3'b111);
        // R9: dropping the reference after start is ignored
        ref_ok = 1'b0;

        // R3 R4 R5: vector walk over the ramps
        for (int i = 0; i < NV; i++) begin
            while (k < VEC[i].k) tick();
            chk("R3 main code", main_code, VEC[i].m);
            chk("R3 pgate code", pgate_code, VEC[i].p);
            chk("R4 ngate code", ngate_code, VEC[i].n);
            chk("R5 done bits", rail_done, VEC[i].dn);
            chk("R9 enables kept", rail_en, 3'b111);
        end

        // R3: codes hold at full scale after done
        tick();
        chk("R3 main holds", main_code, 127);
        chk("R4 ngate holds", ngate_code, 25);

        // R6: switch enable after delay of 10 cycles from all-done (k=508)
        while (k < 517) tick();
        chk("R6 sw_en before terminal", sw_en, 0);
        tick();
        chk("R6 sw_en at terminal", sw_en, 1);

        // R7: supply drop removes enables in the same cycle
        supply_ok = 1'b0;
        #1;
        chk("R7 enables off same cycle", rail_en, 0);
        chk("R7 sw_en off same cycle", sw_en, 0);
        @(negedge clk);
        chk("R7 main back to start", main_code, 0);
        chk("R7 pgate back to start", pgate_code, 0);
        chk("R7 ngate back to start", ngate_code, 127);
        chk("R7 done cleared", rail_done, 0);
        repeat (3) @(negedge clk);

        // R7: repower repeats the full sequence
        supply_ok = 1'b1;
        ref_ok = 1'b1;
        @(negedge clk);
        k = 0;
        chk("R7 restart enables", rail_en, 3'b111);
        chk("R7 restart main start", main_code, 0);
        while (k < 20) tick();
        chk("R7 repeat main", main_code, 5);
        chk("R7 repeat pgate", pgate_code, 10);
        chk("R7 repeat ngate", ngate_code, 121);
        chk("R7 repeat no sw_en", sw_en, 0);

        // R8: fault removes enables at once and freezes the codes
        fm = main_code;
        fp = pgate_code;
        fn = ngate_code;
        fault_lat = 1'b1;
        #1;
        chk("R8 enables off with fault", rail_en, 0);
        repeat (3) @(negedge clk);
        fault_lat = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 main frozen", main_code, fm);
        chk("R8 pgate frozen", pgate_code, fp);
        chk("R8 ngate frozen", ngate_code, fn);
        chk("R8 enables stay off", rail_en, 0);
        chk("R8 sw_en stays off", sw_en, 0);

        // R8: cycling supply releases the fault and restarts
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R8 restart after supply cycle", rail_en, 3'b111);
        chk("R8 restart main code", main_code, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule